// File: doc/BRIEF.md
# Activity-Triggered Power-Down Controller

This controller sits beside a tag memory array and decides, cycle by cycle, whether the array must be powered. It samples the memory's select, write strobe, clear strobe, address bus and data bus on every clock. It compares each sample with the copy it registered one clock earlier. Any qualifying transition counts as activity. Activity reloads an idle counter with a parameterised interval, and the array stays powered while that counter is non-zero.

Power therefore follows how often the array is accessed, not how long it is selected. A select held low with nothing changing still times out. Deselecting the array drops it to standby on the next clock, unless a clear is in progress. All strobes are active low.

Top module: `apd_ctrl`

## Requirements
- R1: A falling edge of `sel_n`, seen between two consecutive clocks, makes `pwr_on` high on the clock after it is seen.
- R2: A falling edge of `wr_n` makes `pwr_on` high on the next clock only when `sel_n` is low in the same sample. With `sel_n` high, the edge has no effect.
- R3: Any change of `addr` between consecutive samples powers up on the next clock only while `sel_n` is low.
- R4: Any change of `data` between consecutive samples powers up on the next clock only while both `sel_n` and `wr_n` are low.
- R5: A falling edge of `clr_n` powers up on the next clock whatever the state of `sel_n` and `wr_n`.
- R6: After the last trigger, `pwr_on` stays high for exactly `IDLE_CYCLES` clocks and then goes low, even while `sel_n` stays low.
- R7: A sample with `sel_n` high and `clr_n` high forces `pwr_on` low on the next clock.
- R8: A new trigger while powered reloads the full interval. The interval then counts from the newest trigger.
- R9: While `rst_n` is low, `pwr_on` is low. The registered copies reset to strobes high and buses zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| sel_n | input | 1 | Array select, active low |
| wr_n | input | 1 | Write strobe, active low |
| clr_n | input | 1 | Array clear strobe, active low |
| addr | input | ADDR_W | Address bus |
| data | input | DATA_W | Data bus |
| pwr_on | output | 1 | High while the array must be powered |

## Verification
Each trigger source is exercised twice: once with its qualifying enables active and once with them inactive. The first run shows that the source wakes the array. The second shows that the gating is not missing, for example a data change with the write strobe high, or a write-strobe fall while deselected. A long select-held idle stretch tells a timeout apart from a level-sensitive select. A mid-interval retrigger tells a reload apart from a counter that only starts from zero. A deselect and a clear issued while deselected separate the standby path from the clear exception.

// File: rtl/apd_ctrl.sv
module apd_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int IDLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              pwr_on
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

  logic              sel_q, wr_q, clr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  idle_cnt;

  wire sel_fall = sel_q & ~sel_n;
  wire wr_fall  = ~sel_n & wr_q & ~wr_n;
  wire addr_chg = ~sel_n & (addr != addr_q);
  wire data_chg = ~sel_n & ~wr_n & (data != data_q);
  wire clr_fall = clr_q & ~clr_n;
  wire wake     = sel_fall | wr_fall | addr_chg | data_chg | clr_fall;
  wire standby  = sel_n & clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      wr_q   <= 1'b1;
      clr_q  <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sel_q  <= sel_n;
      wr_q   <= wr_n;
      clr_q  <= clr_n;
      addr_q <= addr;
      data_q <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (wake)             idle_cnt <= CNT_W'(IDLE_CYCLES);
    else if (standby)          idle_cnt <= '0;
    else if (idle_cnt != '0)   idle_cnt <= idle_cnt - 1'b1;
  end

  assign pwr_on = (idle_cnt != '0);
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              wr_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              pwr_on
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_sel_fall_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(sel_n) |=> pwr_on);
  p_wr_fall_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($fell(wr_n) && !sel_n) |=> pwr_on);
  p_addr_chg_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!sel_n && !$stable(addr)) |=> pwr_on);
  p_data_chg_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!sel_n && !wr_n && !$stable(data)) |=> pwr_on);
  p_clr_fall_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(clr_n) |=> pwr_on);
  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && clr_n) |=> !pwr_on);
  always_comb
    if (!rst_n) p_reset_off_r9: assert (!pwr_on);
endmodule

bind apd_ctrl apd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/apd_ctrl_tb.sv
module apd_ctrl_tb;
  localparam int AW = 13, DW = 8, IDLE = 6;

  logic clk = 0, rst_n = 0, sel_n = 1, wr_n = 1, clr_n = 1, pwr_on;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  always #2.5 clk = ~clk;

  apd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .clr_n(clr_n),
    .addr(addr), .data(data), .pwr_on(pwr_on));

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R9";
  int rem = 0;
  logic p_sel = 1, p_wr = 1, p_clr = 1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_data = '0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: pwr_on=%b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rem = 0; p_sel = 1; p_wr = 1; p_clr = 1; p_addr = '0; p_data = '0;
    end else begin
      bit trig;
      trig = (p_sel && !sel_n) || (!sel_n && p_wr && !wr_n) ||
             (!sel_n && addr != p_addr) || (!sel_n && !wr_n && data != p_data) ||
             (p_clr && !clr_n);
      if (trig) rem = IDLE;
      else if (sel_n && clr_n) rem = 0;
      else if (rem > 0) rem--;
      p_sel = sel_n; p_wr = wr_n; p_clr = clr_n; p_addr = addr; p_data = data;
    end
    #1 check(phase, pwr_on, rem > 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    phase = "R9"; check("R9", pwr_on, 1'b0);
    rst_n = 1; idle(2);
    phase = "R1"; sel_n = 0; idle(1); #2 check("R1", pwr_on, 1'b1);
    phase = "R6"; idle(IDLE + 2); check("R6", pwr_on, 1'b0);
    phase = "R2"; wr_n = 0; idle(1); #2 check("R2", pwr_on, 1'b1);
    wr_n = 1; idle(IDLE + 2); check("R6", pwr_on, 1'b0);
    phase = "R3"; addr = 13'h0a5; idle(1); #2 check("R3", pwr_on, 1'b1);
    idle(IDLE + 2);
    phase = "R4"; data = 8'h3c; idle(2); check("R4", pwr_on, 1'b0);
    wr_n = 0; idle(IDLE + 2);
    data = 8'hc3; idle(1); #2 check("R4", pwr_on, 1'b1);
    idle(IDLE + 2); check("R6", pwr_on, 1'b0);
    phase = "R8"; addr = 13'h001; idle(IDLE - 2);
    addr = 13'h002; idle(IDLE - 1); check("R8", pwr_on, 1'b1);
    idle(2); check("R8", pwr_on, 1'b0);
    phase = "R7"; addr = 13'h003; idle(2); sel_n = 1; wr_n = 1; idle(1); #2 check("R7", pwr_on, 1'b0);
    phase = "R2"; wr_n = 0; idle(1); wr_n = 1; idle(1); check("R2", pwr_on, 1'b0);
    phase = "R3"; addr = 13'h1ff; data = 8'h11; idle(2); check("R3", pwr_on, 1'b0);
    phase = "R5"; clr_n = 0; idle(1); #2 check("R5", pwr_on, 1'b1);
    idle(IDLE + 1); check("R6", pwr_on, 1'b0);
    clr_n = 1; idle(1); #2 check("R7", pwr_on, 1'b0);
    phase = "R9"; rst_n = 0; #1 check("R9", pwr_on, 1'b0);
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule